// File: doc/BRIEF.md
# Software-Loadable Down-Counter with Sign-Change Interrupt

This block is a down-counter that software can read and load. It is W bits wide and uses 32 by default. The count drops by one on each cycle in which the tick enable input is high. When the count's most significant bit changes from 0 to 1, the block sets a sticky interrupt request. That change can happen in two ways:
- counting down from zero, which wraps the count to all ones;
- a software load that makes the value negative while it was non-negative.

The count does not stop after it wraps. Each following tick carries on from all ones, so no tick is lost at the wrap.

A chip can place two copies of this module: one for the ordinary decrementer and one for the hypervisor decrementer. The tick source comes from outside the block, and the interrupt controller takes the level output. The block supplies neither of them.

Top module: `dec_timer`

## Requirements
- R1: While rst_n is low, and in the first sample after reset, rd_data is all ones and irq is 0.
- R2: In a cycle with tick_en high and wr_en low, rd_data after the clock edge equals its old value minus one. With both tick_en and wr_en low, rd_data holds.
- R3: A tick taken at count 0 gives all ones and sets irq. The next tick gives all ones minus one, so counting continues with no lost tick.
- R4: In a cycle with wr_en high, rd_data after the edge equals wr_data. This holds even when tick_en is high in the same cycle.
- R5: A write with wr_data bit W-1 set, made while rd_data bit W-1 is clear, sets irq at the same edge that loads the value.
- R6: A write or a tick that does not take bit W-1 from 0 to 1 does not set irq. This covers writes from 1 to 1, from 1 to 0 and from 0 to 0, and the tick from 0x80000000 to 0x7FFFFFFF.
- R7: Once irq is set, it stays at 1 until a cycle with irq_clear high. After that edge it reads 0, provided no new sign change occurs in that cycle.
- R8: A sign change in the same cycle as irq_clear wins, and irq reads 1 after that edge.
- R9: irq and rd_data are updated by the same clock edge. Neither lags the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Decrement enable, one step per high cycle |
| wr_en | input | 1 | Load the count from wr_data |
| wr_data | input | W | Value to load |
| irq_clear | input | 1 | Clears the pending request |
| rd_data | output | W | Current count |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block twice:
- W=32, the main instance. Writes place it next to zero and next to the sign boundary, which exercises the wrap, the write-driven sign change and the clear-versus-set priority on real 32-bit values.
- W=4. Here a full count from reset down through zero and round to all ones takes only sixteen ticks. This shows the wrap and the sign change with the counter running freely and no write involved.

// File: rtl/dec_timer.sv
module dec_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         irq_clear,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ALL1 = '1;

  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nxt;
  logic         neg_edge;
  logic         irq_q;

  assign cnt_nxt  = wr_en ? wr_data : (tick_en ? cnt - ONE : cnt);
  assign neg_edge = ~cnt[W-1] & cnt_nxt[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= ALL1;
      irq_q <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      irq_q <= neg_edge | (irq_q & ~irq_clear);
    end
  end

  assign rd_data = cnt;
  assign irq     = irq_q;
endmodule

// File: rtl/dec_timer_chk.sv
module dec_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         irq_clear,
  input logic [W-1:0] rd_data,
  input logic         irq
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '1 && !irq));

  a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_en) |=> rd_data == $past(rd_data) - ONE);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> $stable(rd_data));

  a_r3_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_en && rd_data == ZERO) |=> (irq && rd_data == '1));

  a_r4_write_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  a_r5_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[W-1] && !rd_data[W-1]) |=> irq);

  a_r6_quiet_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !tick_en && !wr_en) |=> !irq);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clear) |=> irq);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !tick_en && !wr_en) |=> !irq);
endmodule

bind dec_timer dec_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
  .wr_data(wr_data), .irq_clear(irq_clear), .rd_data(rd_data), .irq(irq)
);

// File: tb/tb_dec_timer.sv
module tb_dec_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, wr_en = 1'b0, irq_clear = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq;
  logic n_tick = 1'b0;
  logic [3:0] n_rd;
  logic n_irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dec_timer #(.W(32)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_data(wr_data), .irq_clear(irq_clear), .rd_data(rd_data), .irq(irq));

  dec_timer #(.W(4)) dut_n (
    .clk(clk), .rst_n(rst_n), .tick_en(n_tick), .wr_en(1'b0),
    .wr_data(4'h0), .irq_clear(1'b0), .rd_data(n_rd), .irq(n_irq));

  // {wr, tick, clr, wdata, exp_rd, exp_irq}
  localparam int NV = 20;
  localparam logic [67:0] VEC [NV] = '{
    {3'b010, 32'h0,        32'hFFFFFFFE, 1'b0}, // R2
    {3'b100, 32'h00000002, 32'h00000002, 1'b0}, // R4
    {3'b010, 32'h0,        32'h00000001, 1'b0}, // R2
    {3'b000, 32'h0,        32'h00000001, 1'b0}, // R2 hold
    {3'b010, 32'h0,        32'h00000000, 1'b0}, // R2
    {3'b010, 32'h0,        32'hFFFFFFFF, 1'b1}, // R3 R9
    {3'b010, 32'h0,        32'hFFFFFFFE, 1'b1}, // R3 R7
    {3'b001, 32'h0,        32'hFFFFFFFE, 1'b0}, // R7
    {3'b100, 32'h80000000, 32'h80000000, 1'b0}, // R6 1->1
    {3'b010, 32'h0,        32'h7FFFFFFF, 1'b0}, // R6 tick
    {3'b110, 32'h00000005, 32'h00000005, 1'b0}, // R4 priority
    {3'b100, 32'h90000000, 32'h90000000, 1'b1}, // R5
    {3'b101, 32'h00000010, 32'h00000010, 1'b0}, // R7
    {3'b100, 32'h00000000, 32'h00000000, 1'b0}, // R6 0->0
    {3'b011, 32'h0,        32'hFFFFFFFF, 1'b1}, // R8 tick
    {3'b100, 32'h40000000, 32'h40000000, 1'b1}, // R6 1->0, R7
    {3'b001, 32'h0,        32'h40000000, 1'b0}, // R7
    {3'b100, 32'h12345678, 32'h12345678, 1'b0}, // R6 0->0
    {3'b101, 32'h80000001, 32'h80000001, 1'b1}, // R8 write
    {3'b001, 32'h0,        32'h80000001, 1'b0}  // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic t, input logic c, input logic [31:0] d);
    @(negedge clk);
    wr_en = w; tick_en = t; irq_clear = c; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0; tick_en = 1'b0; irq_clear = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 rd", rd_data, 32'hFFFFFFFF);
    check("R1 irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after release rd", rd_data, 32'hFFFFFFFF);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][67], VEC[i][66], VEC[i][65], VEC[i][64:33]);
      check($sformatf("vec%0d rd", i), rd_data, VEC[i][32:1]);
      check($sformatf("vec%0d irq", i), {31'b0, irq}, {31'b0, VEC[i][0]});
    end
    // R1: reset mid-run clears pending state
    step(1'b1, 1'b0, 1'b0, 32'h0);
    step(1'b0, 1'b1, 1'b0, 32'h0);
    check("R3 pre-reset irq", {31'b0, irq}, 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1 mid reset rd", rd_data, 32'hFFFFFFFF);
    check("R1 mid reset irq", {31'b0, irq}, 32'h0);
    check("R1 small rd", {28'b0, n_rd}, 32'hF);
    @(negedge clk);
    rst_n = 1'b1;
    // R3: free-running wrap on the narrow instance
    for (int k = 0; k < 15; k++) begin
      @(negedge clk); n_tick = 1'b1;
    end
    @(negedge clk); n_tick = 1'b0;
    check("R3 small at zero rd", {28'b0, n_rd}, 32'h0);
    check("R3 small at zero irq", {31'b0, n_irq}, 32'h0);
    n_tick = 1'b1;
    @(negedge clk);
    check("R3 small wrap rd", {28'b0, n_rd}, 32'hF);
    check("R3 small wrap irq", {31'b0, n_irq}, 32'h1);
    @(negedge clk); n_tick = 1'b0;
    check("R3 small continue rd", {28'b0, n_rd}, 32'hE);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule